// File: doc/BRIEF.md
# Carrying Integer Add Execute Unit

This execute unit decodes one 32-bit instruction word per strobe and runs the carrying members of the integer add family. These are plain add-carrying (A + B), add-extended (A + B + CA), add-to-zero-extended (A + CA) and add-to-minus-one-extended (A + CA + all ones). Each form always produces a 64-bit sum and a new carry bit. When the overflow-enable flag is set, it also produces a signed-overflow bit and a sticky summary-overflow bit. When the record flag is set, it rewrites the four-bit condition field from a signed compare of the sum against zero.

The surrounding pipeline supplies the operand values already read from the register file, together with the present carry, overflow, summary-overflow and condition-field state. One cycle after the strobe, the unit returns the destination index, the sum with a write enable, and the next value of each status bit. A word that is not one of the four supported forms raises an illegal flag. In that case every status output repeats its input, so no architectural state moves. A separate clear input models the single instruction that can reset the summary-overflow bit.

Top module: `carry_add_xu`

## Requirements
- R1: Instruction bits are numbered so that `instr[31]` is bit 0. Fields are: primary opcode `instr[31:26]`, destination `instr[25:21]`, OE `instr[10]`, 9-bit extended opcode `instr[9:1]`, Rc `instr[0]`. A word is legal only if the primary opcode is 31 and the extended opcode is 10, 138, 202 or 234. For any other strobed word, `illegal` is 1 for one cycle and `wb_en` is 0. Carry, overflow, summary and `cr0_out` equal their inputs, apart from the clear of R9.
- R2: Extended opcode 10 (add-carrying) produces `wb_data = A + B` mod 2^64 with `wb_idx` equal to the destination field. `wb_en` is 1 in the cycle after the strobe. When idle, `wb_en` and `illegal` are 0.
- R3: For every legal form, `xer_ca_out` is the carry out of bit 63 of the full addition, whatever the values of OE and Rc.
- R4: Extended opcode 138 (add-extended) produces A + B + CA, where CA is `xer_ca_in`.
- R5: Extended opcode 202 produces A + CA. Extended opcode 234 produces A + CA + 0xFFFF_FFFF_FFFF_FFFF. Both ignore B.
- R6: With OE=1, `xer_ov_out` is 1 exactly when the signed addition overflows 64 bits, and `xer_so_out` is the summary input ORed with that overflow. No trap is raised.
- R7: With OE=0, or on an idle or illegal cycle, `xer_ov_out` equals `xer_ov_in`, and the summary bit is not set by the add.
- R8: With Rc=1, `cr0_out` = {LT, GT, EQ, SO} (bits 3 to 0), taken from a full 64-bit signed compare of the sum with zero. Exactly one of LT, GT and EQ is set, and SO equals the updated `xer_so_out`. With Rc=0, `cr0_out` equals `cr0_in`.
- R9: `so_clr` forces the incoming summary bit to 0 before any OR from this cycle's overflow. No instruction clears the summary bit on its own.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| opnd_a | input | 64 | Source A value |
| opnd_b | input | 64 | Source B value |
| xer_ca_in | input | 1 | Current carry bit |
| xer_ov_in | input | 1 | Current overflow bit |
| xer_so_in | input | 1 | Current summary-overflow bit |
| cr0_in | input | 4 | Current condition field {LT,GT,EQ,SO} |
| so_clr | input | 1 | Clear summary-overflow |
| wb_en | output | 1 | Destination write enable |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 64 | Sum |
| xer_ca_out | output | 1 | Next carry bit |
| xer_ov_out | output | 1 | Next overflow bit |
| xer_so_out | output | 1 | Next summary-overflow bit |
| cr0_out | output | 4 | Next condition field |
| illegal | output | 1 | Unsupported instruction word |

## Verification
The sweep crosses boundary operands (zero, one, all ones, the most negative and most positive values) with every form, both carry-in values and both flag bits. A design that took the carry-in for add-carrying, or dropped it in the chained forms, fails R3 to R5 at the all-ones edges. Signed overflow is checked where both operands are near the sign boundary. An unsigned overflow test instead of a signed one fails R6. The record form is checked with a sum of zero and with negative sums. A compare on only the low 32 bits, or a copy of the stale summary bit into SO, fails R8. Illegal words, idle cycles and a clear that coincides with an overflow show whether state leaks or whether the clear is applied in the wrong order.

// File: rtl/cadd_pkg.sv
package cadd_pkg;

   localparam int unsigned PRIMARY_OPC  = 31;
   localparam int unsigned XO_ADD_CARRY = 10;
   localparam int unsigned XO_ADD_EXT   = 138;
   localparam int unsigned XO_ADD_ZERO  = 202;
   localparam int unsigned XO_ADD_MONE  = 234;

   typedef enum logic [1:0] {
      OP_CARRY = 2'd0,
      OP_EXT   = 2'd1,
      OP_ZERO  = 2'd2,
      OP_MONE  = 2'd3
   } cadd_op_e;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } cond_field_t;

endpackage

// File: rtl/cadd_decode.sv
module cadd_decode
   import cadd_pkg::*;
#(
   parameter int unsigned IW   = 32,
   parameter int unsigned IDXW = 5
) (
   input  logic [IW-1:0]   instr,
   output logic            legal,
   output cadd_op_e        op,
   output logic [IDXW-1:0] dest,
   output logic            oe,
   output logic            rc
);
   localparam int unsigned OPC_W = 6;
   localparam int unsigned XO_W  = 9;
   localparam int unsigned OPC_LO = IW - OPC_W;
   localparam int unsigned RT_LO  = OPC_LO - IDXW;
   localparam int unsigned OE_POS = XO_W + 1;

   logic [OPC_W-1:0] opc;
   logic [XO_W-1:0]  xo;
   logic             unused_src;

   assign opc  = instr[IW-1:OPC_LO];
   assign dest = instr[OPC_LO-1:RT_LO];
   assign oe   = instr[OE_POS];
   assign xo   = instr[XO_W:1];
   assign rc   = instr[0];
   assign unused_src = ^instr[RT_LO-1:OE_POS+1];

   always_comb begin
      legal = (opc == OPC_W'(PRIMARY_OPC));
      op    = OP_CARRY;
      unique case (xo)
         XO_W'(XO_ADD_CARRY): op = OP_CARRY;
         XO_W'(XO_ADD_EXT):   op = OP_EXT;
         XO_W'(XO_ADD_ZERO):  op = OP_ZERO;
         XO_W'(XO_ADD_MONE):  op = OP_MONE;
         default:             legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/cadd_adder.sv
module cadd_adder #(
   parameter int unsigned XLEN  = 64,
   parameter bit          SPLIT = 1'b0
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            cin,
   output logic [XLEN-1:0] sum,
   output logic            cout,
   output logic            sovf
);
   localparam int unsigned HALF = XLEN / 2;

   generate
      if (SPLIT) begin : g_split
         logic [HALF:0]      lo;
         logic [XLEN-HALF:0] hi;
         assign lo = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
         assign hi = {1'b0, a[XLEN-1:HALF]} + {1'b0, b[XLEN-1:HALF]}
                   + {{(XLEN-HALF){1'b0}}, lo[HALF]};
         assign sum  = {hi[XLEN-HALF-1:0], lo[HALF-1:0]};
         assign cout = hi[XLEN-HALF];
      end else begin : g_flat
         logic [XLEN:0] full;
         assign full = {1'b0, a} + {1'b0, b} + {{XLEN{1'b0}}, cin};
         assign sum  = full[XLEN-1:0];
         assign cout = full[XLEN];
      end
   endgenerate

   assign sovf = (a[XLEN-1] == b[XLEN-1]) && (sum[XLEN-1] != a[XLEN-1]);
endmodule

// File: rtl/cadd_flags.sv
module cadd_flags
   import cadd_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic            exec,
   input  logic            oe,
   input  logic            rc,
   input  logic [XLEN-1:0] sum,
   input  logic            cout,
   input  logic            sovf,
   input  logic            ca_in,
   input  logic            ov_in,
   input  logic            so_in,
   input  logic            so_clr,
   input  cond_field_t     cr_in,
   output logic            ca_nx,
   output logic            ov_nx,
   output logic            so_nx,
   output cond_field_t     cr_nx
);
   logic so_base;
   logic ov_upd;

   assign so_base = so_in & ~so_clr;
   assign ov_upd  = exec & oe;

   always_comb begin
      ca_nx = exec ? cout : ca_in;
      ov_nx = ov_upd ? sovf : ov_in;
      so_nx = so_base | (ov_upd & sovf);
      cr_nx = cr_in;
      if (exec && rc) begin
         cr_nx.lt = sum[XLEN-1];
         cr_nx.eq = (sum == '0);
         cr_nx.gt = ~sum[XLEN-1] & (sum != '0);
         cr_nx.so = so_nx;
      end
   end
endmodule

// File: rtl/carry_add_xu.sv
module carry_add_xu
   import cadd_pkg::*;
#(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned IW    = 32,
   parameter int unsigned IDXW  = 5,
   parameter bit          SPLIT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            issue_vld,
   input  logic [31:0]     instr,
   input  logic [63:0]     opnd_a,
   input  logic [63:0]     opnd_b,
   input  logic            xer_ca_in,
   input  logic            xer_ov_in,
   input  logic            xer_so_in,
   input  logic [3:0]      cr0_in,
   input  logic            so_clr,
   output logic            wb_en,
   output logic [4:0]      wb_idx,
   output logic [63:0]     wb_data,
   output logic            xer_ca_out,
   output logic            xer_ov_out,
   output logic            xer_so_out,
   output logic [3:0]      cr0_out,
   output logic            illegal
);
   generate
      if (IW != 32) begin : g_bad_iw
         $error("carry_add_xu: IW must be 32");
      end
      if (XLEN != 64) begin : g_bad_xlen
         $error("carry_add_xu: XLEN must match the 64-bit port width");
      end
      if (IDXW != 5) begin : g_bad_idx
         $error("carry_add_xu: IDXW must be 5");
      end
   endgenerate

   logic            legal;
   cadd_op_e        op;
   logic [IDXW-1:0] dest;
   logic            oe, rc, exec;
   logic [XLEN-1:0] b_sel, sum;
   logic            cin, cout, sovf;
   logic            ca_nx, ov_nx, so_nx;
   cond_field_t     cr_nx;

   cadd_decode #(.IW(IW), .IDXW(IDXW)) dec_i (
      .instr (instr),
      .legal (legal),
      .op    (op),
      .dest  (dest),
      .oe    (oe),
      .rc    (rc)
   );

   always_comb begin
      unique case (op)
         OP_CARRY: begin b_sel = opnd_b; cin = 1'b0;      end
         OP_EXT:   begin b_sel = opnd_b; cin = xer_ca_in; end
         OP_ZERO:  begin b_sel = '0;     cin = xer_ca_in; end
         default:  begin b_sel = '1;     cin = xer_ca_in; end
      endcase
   end

   cadd_adder #(.XLEN(XLEN), .SPLIT(SPLIT)) add_i (
      .a    (opnd_a),
      .b    (b_sel),
      .cin  (cin),
      .sum  (sum),
      .cout (cout),
      .sovf (sovf)
   );

   assign exec = issue_vld & legal;

   cadd_flags #(.XLEN(XLEN)) flg_i (
      .exec   (exec),
      .oe     (oe),
      .rc     (rc),
      .sum    (sum),
      .cout   (cout),
      .sovf   (sovf),
      .ca_in  (xer_ca_in),
      .ov_in  (xer_ov_in),
      .so_in  (xer_so_in),
      .so_clr (so_clr),
      .cr_in  (cond_field_t'(cr0_in)),
      .ca_nx  (ca_nx),
      .ov_nx  (ov_nx),
      .so_nx  (so_nx),
      .cr_nx  (cr_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_en      <= 1'b0;
         wb_idx     <= '0;
         wb_data    <= '0;
         xer_ca_out <= 1'b0;
         xer_ov_out <= 1'b0;
         xer_so_out <= 1'b0;
         cr0_out    <= '0;
         illegal    <= 1'b0;
      end else begin
         wb_en      <= exec;
         wb_idx     <= dest;
         wb_data    <= sum;
         xer_ca_out <= ca_nx;
         xer_ov_out <= ov_nx;
         xer_so_out <= so_nx;
         cr0_out    <= cr_nx;
         illegal    <= issue_vld & ~legal;
      end
   end
endmodule

// File: rtl/cadd_checker.sv
module cadd_checker #(
   parameter int unsigned XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            issue_vld,
   input logic            oe_bit,
   input logic            rc_bit,
   input logic            ca_in,
   input logic            ov_in,
   input logic            so_in,
   input logic [3:0]      cr0_in,
   input logic            so_clr,
   input logic            wb_en,
   input logic [XLEN-1:0] wb_data,
   input logic            ca_out,
   input logic            ov_out,
   input logic            so_out,
   input logic [3:0]      cr0_out,
   input logic            illegal
);
   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_illegal_no_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !wb_en);

   assert_illegal_keeps_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && illegal) |-> (ca_out == $past(ca_in) && cr0_out == $past(cr0_in)
                              && ov_out == $past(ov_in)));

   assert_so_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(so_in) && !$past(so_clr)) |-> so_out);

   assert_ov_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(issue_vld && oe_bit)) |-> (ov_out == $past(ov_in)));

   assert_cr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wb_en && $past(rc_bit)) |-> ($countones(cr0_out[3:1]) == 1));

   assert_cr_so_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wb_en && $past(rc_bit)) |-> (cr0_out[0] == so_out));

   assert_cr_eq_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wb_en && $past(rc_bit)) |-> (cr0_out[1] == (wb_data == '0)));

   assert_cr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(issue_vld && rc_bit)) |-> (cr0_out == $past(cr0_in)));
endmodule

bind carry_add_xu cadd_checker #(.XLEN(XLEN)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .issue_vld (issue_vld),
   .oe_bit    (instr[10]),
   .rc_bit    (instr[0]),
   .ca_in     (xer_ca_in),
   .ov_in     (xer_ov_in),
   .so_in     (xer_so_in),
   .cr0_in    (cr0_in),
   .so_clr    (so_clr),
   .wb_en     (wb_en),
   .wb_data   (wb_data),
   .ca_out    (xer_ca_out),
   .ov_out    (xer_ov_out),
   .so_out    (xer_so_out),
   .cr0_out   (cr0_out),
   .illegal   (illegal)
);

// File: tb/carry_add_xu_tb_top.sv
module carry_add_xu_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_vld = 1'b0;
   logic [31:0] instr = '0;
   logic [63:0] opnd_a = '0, opnd_b = '0;
   logic        xer_ca_in = 1'b0, xer_ov_in = 1'b0, xer_so_in = 1'b0;
   logic [3:0]  cr0_in = '0;
   logic        so_clr = 1'b0;
   logic        wb_en, xer_ca_out, xer_ov_out, xer_so_out, illegal;
   logic [4:0]  wb_idx;
   logic [63:0] wb_data;
   logic [3:0]  cr0_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   carry_add_xu dut_i (
      .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .instr(instr),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .xer_ca_in(xer_ca_in),
      .xer_ov_in(xer_ov_in), .xer_so_in(xer_so_in), .cr0_in(cr0_in),
      .so_clr(so_clr), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
      .xer_ca_out(xer_ca_out), .xer_ov_out(xer_ov_out),
      .xer_so_out(xer_so_out), .cr0_out(cr0_out), .illegal(illegal)
   );

   function automatic logic [63:0] corner(input int k);
      case (k)
         0: return 64'h0;
         1: return 64'h1;
         2: return 64'hFFFF_FFFF_FFFF_FFFF;
         3: return 64'h8000_0000_0000_0000;
         4: return 64'h7FFF_FFFF_FFFF_FFFF;
         5: return 64'h0000_0000_FFFF_FFFF;
         6: return 64'h8000_0000_0000_0001;
         default: return 64'h5A5A_0123_89AB_F00F;
      endcase
   endfunction

   function automatic logic [8:0] xo_of(input int f);
      case (f)
         0: return 9'd10;
         1: return 9'd138;
         2: return 9'd202;
         default: return 9'd234;
      endcase
   endfunction

   function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rt,
                                      input logic [8:0] xo, input logic oe, input logic rc);
      return {opc, rt, 5'd3, 5'd4, oe, xo, rc};
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk);
      #1;
   endtask

   // Drive one legal instruction and compare every output against arithmetic.
   task automatic run_legal(input int f, input logic [63:0] a, input logic [63:0] b,
                            input logic ca, input logic ov, input logic so,
                            input logic oe, input logic rc, input logic clr,
                            input logic [4:0] rt, input logic [3:0] cri);
      logic [63:0] bs, s;
      logic        cin, c, ovx, sob, ov_e, so_e;
      logic [64:0] full;
      logic signed [65:0] tru, ext;
      logic [3:0]  cr_e;
      string rq;
      case (f)
         0: begin bs = b;   cin = 1'b0; rq = "R2/R3"; end
         1: begin bs = b;   cin = ca;   rq = "R4";    end
         2: begin bs = '0;  cin = ca;   rq = "R5";    end
         default: begin bs = '1; cin = ca; rq = "R5"; end
      endcase
      full = {1'b0, a} + {1'b0, bs} + {64'd0, cin};
      s = full[63:0];
      c = full[64];
      tru = $signed({{2{a[63]}}, a}) + $signed({{2{bs[63]}}, bs}) + $signed({65'd0, cin});
      ext = $signed({{2{s[63]}}, s});
      ovx = (tru != ext);
      sob = so & ~clr;
      ov_e = oe ? ovx : ov;
      so_e = oe ? (sob | ovx) : sob;
      cr_e = rc ? {s[63], (!s[63] && s != 0), (s == 0), so_e} : cri;

      issue_vld = 1'b1; instr = mk(6'd31, rt, xo_of(f), oe, rc);
      opnd_a = a; opnd_b = b; xer_ca_in = ca; xer_ov_in = ov; xer_so_in = so;
      cr0_in = cri; so_clr = clr;
      step();
      chk(rq, "sum", wb_data, s);
      chk("R2", "wb_en", {63'd0, wb_en}, 64'd1);
      chk("R2", "wb_idx", {59'd0, wb_idx}, {59'd0, rt});
      chk("R3", "carry", {63'd0, xer_ca_out}, {63'd0, c});
      chk(oe ? "R6" : "R7", "ov", {63'd0, xer_ov_out}, {63'd0, ov_e});
      chk(clr ? "R9" : (oe ? "R6" : "R7"), "so", {63'd0, xer_so_out}, {63'd0, so_e});
      chk("R8", "cr0", {60'd0, cr0_out}, {60'd0, cr_e});
      chk("R1", "illegal", {63'd0, illegal}, 64'd0);
   endtask

   task automatic run_passthru(input logic vld, input logic [31:0] w,
                               input logic ca, input logic ov, input logic so,
                               input logic clr, input logic [3:0] cri);
      issue_vld = vld; instr = w; opnd_a = 64'hFFFF_FFFF_FFFF_FFFF; opnd_b = 64'h1;
      xer_ca_in = ca; xer_ov_in = ov; xer_so_in = so; cr0_in = cri; so_clr = clr;
      step();
      chk(vld ? "R1" : "R2", "illegal", {63'd0, illegal}, {63'd0, vld});
      chk("R1", "wb_en", {63'd0, wb_en}, 64'd0);
      chk("R1", "carry", {63'd0, xer_ca_out}, {63'd0, ca});
      chk("R7", "ov", {63'd0, xer_ov_out}, {63'd0, ov});
      chk("R9", "so", {63'd0, xer_so_out}, {63'd0, so & ~clr});
      chk("R1", "cr0", {60'd0, cr0_out}, {60'd0, cri});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      xer_ca_in = 1'b1; xer_so_in = 1'b1; cr0_in = 4'hF; issue_vld = 1'b1;
      instr = mk(6'd31, 5'd7, 9'd10, 1'b1, 1'b1);
      repeat (3) step();
      // R10: reset state
      chk("R10", "wb_en", {63'd0, wb_en}, 64'd0);
      chk("R10", "wb_data", wb_data, 64'd0);
      chk("R10", "status", {58'd0, xer_ca_out, xer_ov_out, xer_so_out, illegal, 2'b0}, 64'd0);
      chk("R10", "cr0", {60'd0, cr0_out}, 64'd0);
      issue_vld = 1'b0;
      rst_n = 1'b1;

      // Near-exhaustive sweep of corner operands over all forms and flags.
      for (int f = 0; f < 4; f++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
               for (int k = 0; k < 16; k++)
                  run_legal(f, corner(i), corner(j), k[0], k[1], k[2], k[3],
                            k[1] ^ k[3], 1'b0, 5'(i * 4 + j + f), 4'(k));

      // R9: clear without overflow, clear coinciding with overflow.
      run_legal(0, 64'h1, 64'h1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 5'd2, 4'h0);
      run_legal(0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
                5'd9, 4'h0);
      run_legal(1, 64'h1, 64'h1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 5'd31, 4'h0);

      // R1: illegal words; R2: idle cycles.
      for (int m = 0; m < 16; m++) begin
         run_passthru(1'b1, mk(6'd30, 5'd1, 9'd10, m[0], m[1]), m[2], m[3], m[0], 1'b0, 4'(m));
         run_passthru(1'b1, mk(6'd31, 5'd1, 9'd266, m[0], m[1]), m[1], m[2], m[3], m[0], 4'(15 - m));
         run_passthru(1'b1, mk(6'd31, 5'd1, 9'(11 + m), 1'b1, 1'b1), m[0], m[1], 1'b1, m[2], 4'(m));
         run_passthru(1'b0, mk(6'd31, 5'd1, 9'd10, 1'b1, 1'b1), m[3], m[2], m[1], m[0], 4'(m));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule